// File: doc/BRIEF.md
# Programmed-I/O Command Sequencer

This block runs one software-started transaction to a touch controller, or to the register file of an internal bus bridge. Software loads a byte count, a target address, an opcode and up to `N_WORDS` 32-bit data words into a small register file. It then sets a self-clearing start bit in the control register. The opcode selects the operation type: read, write, or write followed by read. It also selects whether the bridge or the external device is the target.

The bus-side wire engine is outside this block. The sequencer talks to it through a request/acknowledge handshake that moves one 32-bit word per acknowledge, with the words taken in ascending index order. Read words land in the same data registers that supplied the write words. When the operation ends, the block sets a done flag, drops busy and can raise a level interrupt. While an operation runs, the programming registers are locked. A write to a locked register is dropped and sets a sticky error flag.

Register offsets on `reg_addr` / `reg_raddr`:
- 0 is control: opcode in [7:0], start in [8], interrupt enable in [9].
- 1 is length: primary byte count in [7:0], write-phase byte count for the combined operation in [15:8].
- 2 is the target address in [15:0].
- 3 is status: done [0], busy [1], bad opcode [2], locked-write error [3]. Bits 0, 2 and 3 are cleared by writing 1.
- 4 to 4+N_WORDS-1 are the data words.

Top module: `pio_seq_top`

## Requirements
- R1: Writing control with bit 8 set while idle starts an operation. Busy (status bit 1) then reads 1, and control bit 8 reads back 0 once the sequencer has left idle. `bus_req` is only ever high while busy.
- R2: Opcode 0x12 reads the bridge, 0x13 writes the bridge, 0x14 reads the device, 0x18 writes the device and 0x1C writes then reads the device. `bus_write` is 1 on write beats. `bus_bridge` is 1 only for 0x12 and 0x13.
- R3: For bridge opcodes, `bus_addr` carries target address bits [7:0] with bits [15:8] forced to zero. Device opcodes pass all 16 bits.
- R4: A phase with byte count C issues min(ceil(C/4), N_WORDS) beats. A count of 0 issues no beats. Beat k sends data word k.
- R5: On read beat k, `bus_rdata` at the acknowledge is stored into data word k.
- R6: Opcode 0x1C first writes the number of beats given by length [15:8] from the data words, and then reads the number of beats given by length [7:0] into the data words starting at word 0.
- R7: When an operation ends, status done is set in the same cycle that busy clears. Writing 1 to status bit 0 clears done, and a new start also clears it.
- R8: `irq` is high exactly while done is set and interrupt enable was set in the control word that started the operation.
- R9: Writes to control, length, address or data while busy leave those registers unchanged and set status bit 3. Bit 3 stays set until software writes 1 to it.
- R10: An opcode outside the five listed issues no bus request. It sets status bit 2 and done two cycles after the start write.
- R11: Once `bus_req` is high it stays high, with `bus_addr`, `bus_wdata` and `bus_write` unchanged, until `bus_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register write offset |
| reg_wdata | input | 32 | Register write data |
| reg_raddr | input | 4 | Register read offset |
| reg_rdata | output | 32 | Register read data (combinational) |
| bus_req | output | 1 | Beat request to the wire engine |
| bus_write | output | 1 | Beat direction, 1 = write |
| bus_bridge | output | 1 | Target is the internal bridge |
| bus_addr | output | 16 | Target address |
| bus_wdata | output | 32 | Write word for the current beat |
| bus_ack | input | 1 | Beat accepted / read word valid |
| bus_rdata | input | 32 | Read word, valid with `bus_ack` |
| irq | output | 1 | Completion interrupt |

## Verification
The assertions assume that the wire engine raises `bus_ack` only while `bus_req` is high, and holds it for a single cycle per beat. They also assume `bus_rdata` is meaningful only in that cycle. The bench's responder model keeps to this. It drops acknowledge for at least one cycle after every beat, and it acknowledges only a pending request after a programmable delay. That delay lets the lock and stability checks see many cycles of a held request. Register writes are applied on the falling edge, one offset at a time, so the lock and start decisions never race against the sequencer.

// File: rtl/pio_pkg.sv
package pio_pkg;
  // opcode values decoded by the sequencer
  localparam logic [7:0] OP_BRG_RD  = 8'h12;
  localparam logic [7:0] OP_BRG_WR  = 8'h13;
  localparam logic [7:0] OP_DEV_RD  = 8'h14;
  localparam logic [7:0] OP_DEV_WR  = 8'h18;
  localparam logic [7:0] OP_DEV_WRD = 8'h1C;

  // register offsets
  localparam int REG_CTRL   = 0;
  localparam int REG_LEN    = 1;
  localparam int REG_TADDR  = 2;
  localparam int REG_STAT   = 3;
  localparam int REG_DBASE  = 4;

  // control / status bit positions
  localparam int CTRL_GO    = 8;
  localparam int CTRL_IE    = 9;
  localparam int ST_DONE    = 0;
  localparam int ST_BUSY    = 1;
  localparam int ST_OPERR   = 2;
  localparam int ST_LOCKERR = 3;

  typedef enum logic [1:0] {S_IDLE, S_WR, S_RD, S_FIN} seq_state_e;
endpackage

// File: rtl/pio_opdec.sv
module pio_opdec
  import pio_pkg::*;
(
  input  logic [7:0] opcode,
  output logic       valid,
  output logic       do_wr,
  output logic       do_rd,
  output logic       bridge
);
  always_comb begin
    valid  = 1'b1;
    do_wr  = 1'b0;
    do_rd  = 1'b0;
    bridge = 1'b0;
    case (opcode)
      OP_BRG_RD:  begin do_rd = 1'b1; bridge = 1'b1; end
      OP_BRG_WR:  begin do_wr = 1'b1; bridge = 1'b1; end
      OP_DEV_RD:  do_rd = 1'b1;
      OP_DEV_WR:  do_wr = 1'b1;
      OP_DEV_WRD: begin do_wr = 1'b1; do_rd = 1'b1; end
      default:    valid = 1'b0;
    endcase
  end
endmodule

// File: rtl/pio_dbank.sv
module pio_dbank #(
  parameter int N_WORDS = 4,
  parameter int DW      = 32,
  localparam int IW     = (N_WORDS > 1) ? $clog2(N_WORDS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sw_we,
  input  logic [IW-1:0]          sw_idx,
  input  logic [DW-1:0]          sw_wdata,
  input  logic                   hw_we,
  input  logic [IW-1:0]          hw_idx,
  input  logic [DW-1:0]          hw_wdata,
  output logic [N_WORDS-1:0][DW-1:0] words
);
  for (genvar i = 0; i < N_WORDS; i++) begin : g_word
    logic [DW-1:0] word_q, word_n;
    logic          sw_hit, hw_hit;

    assign sw_hit = sw_we && (sw_idx == IW'(i));
    assign hw_hit = hw_we && (hw_idx == IW'(i));

    always_comb begin
      word_n = word_q;
      if (hw_hit)      word_n = hw_wdata;
      else if (sw_hit) word_n = sw_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) word_q <= '0;
      else if (sw_hit || hw_hit) word_q <= word_n;
    end

    assign words[i] = word_q;
  end

  // software and bus never load the bank in the same cycle (sw only when idle)
  p_one_writer_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(sw_we && hw_we));
endmodule

// File: rtl/pio_seq.sv
module pio_seq
  import pio_pkg::*;
#(
  parameter int N_WORDS = 4,
  localparam int IW     = (N_WORDS > 1) ? $clog2(N_WORDS) : 1,
  localparam int BW     = $clog2(N_WORDS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          valid,
  input  logic          do_wr,
  input  logic          do_rd,
  input  logic [BW-1:0] wbeats,
  input  logic [BW-1:0] rbeats,
  input  logic          bus_ack,
  output logic          busy,
  output logic          in_wr,
  output logic          req,
  output logic [IW-1:0] idx,
  output logic          rd_stb,
  output logic          finish
);
  seq_state_e    state_q, state_n;
  logic [IW-1:0] idx_q, idx_n;
  logic          last_wr, last_rd;

  assign last_wr = (BW'(idx_q) + BW'(1)) == wbeats;
  assign last_rd = (BW'(idx_q) + BW'(1)) == rbeats;

  always_comb begin
    state_n = state_q;
    idx_n   = idx_q;
    case (state_q)
      S_IDLE: if (start) begin
        idx_n = '0;
        if (!valid)                       state_n = S_FIN;
        else if (do_wr && wbeats != '0)   state_n = S_WR;
        else if (do_rd && rbeats != '0)   state_n = S_RD;
        else                              state_n = S_FIN;
      end
      S_WR: if (bus_ack) begin
        if (last_wr) begin
          idx_n   = '0;
          state_n = (do_rd && rbeats != '0) ? S_RD : S_FIN;
        end else begin
          idx_n = idx_q + IW'(1);
        end
      end
      S_RD: if (bus_ack) begin
        if (last_rd) begin
          idx_n   = '0;
          state_n = S_FIN;
        end else begin
          idx_n = idx_q + IW'(1);
        end
      end
      default: state_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      idx_q   <= '0;
    end else begin
      state_q <= state_n;
      idx_q   <= idx_n;
    end
  end

  assign busy   = state_q != S_IDLE;
  assign in_wr  = state_q == S_WR;
  assign req    = (state_q == S_WR) || (state_q == S_RD);
  assign idx    = idx_q;
  assign rd_stb = (state_q == S_RD) && bus_ack;
  assign finish = state_q == S_FIN;

  // R11: a pending request is not withdrawn before it is acknowledged
  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    req && !bus_ack |=> req);
  // R6: the write phase is never entered straight from the read phase
  p_wr_before_rd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == S_RD |=> state_q != S_WR);
endmodule

// File: rtl/pio_seq_top.sv
module pio_seq_top
  import pio_pkg::*;
#(
  parameter int N_WORDS = 4,
  parameter int AW      = 4,
  parameter int DW      = 32,
  parameter int TW      = 16,
  localparam int IW     = (N_WORDS > 1) ? $clog2(N_WORDS) : 1,
  localparam int BW     = $clog2(N_WORDS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  input  logic [AW-1:0] reg_raddr,
  output logic [DW-1:0] reg_rdata,
  output logic          bus_req,
  output logic          bus_write,
  output logic          bus_bridge,
  output logic [TW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic          bus_ack,
  input  logic [DW-1:0] bus_rdata,
  output logic          irq
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_ns;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ns = rst_sync_q[1];

  // programming registers
  logic [7:0]    opcode_q, opcode_n;
  logic          ie_q, ie_n;
  logic          go_q, go_n;
  logic [15:0]   len_q, len_n;
  logic [TW-1:0] taddr_q, taddr_n;
  logic          done_q, done_n, operr_q, operr_n, lockerr_q, lockerr_n;

  logic          busy, seq_busy, in_wr, seq_req, rd_stb, finish;
  logic [IW-1:0] idx;
  logic          op_valid, do_wr, do_rd, op_bridge;
  logic [BW-1:0] wbeats, rbeats;
  logic [N_WORDS-1:0][DW-1:0] words;

  logic          hit_ctrl, hit_len, hit_taddr, hit_stat, hit_data;
  logic [AW-1:0] doff;

  assign busy      = go_q || seq_busy;
  assign hit_ctrl  = reg_addr == AW'(REG_CTRL);
  assign hit_len   = reg_addr == AW'(REG_LEN);
  assign hit_taddr = reg_addr == AW'(REG_TADDR);
  assign hit_stat  = reg_addr == AW'(REG_STAT);
  assign doff      = reg_addr - AW'(REG_DBASE);
  assign hit_data  = (reg_addr >= AW'(REG_DBASE)) && (doff < AW'(N_WORDS));

  function automatic logic [BW-1:0] to_beats(input logic [7:0] nbytes);
    logic [8:0] w;
    w = ({1'b0, nbytes} + 9'd3) >> 2;
    if (w > 9'(N_WORDS)) return BW'(N_WORDS);
    return BW'(w);
  endfunction

  pio_opdec u_dec (
    .opcode (opcode_q),
    .valid  (op_valid),
    .do_wr  (do_wr),
    .do_rd  (do_rd),
    .bridge (op_bridge)
  );

  assign wbeats = to_beats((do_wr && do_rd) ? len_q[15:8] : len_q[7:0]);
  assign rbeats = to_beats(len_q[7:0]);

  pio_seq #(.N_WORDS(N_WORDS)) u_seq (
    .clk     (clk),
    .rst_n   (rst_ns),
    .start   (go_q),
    .valid   (op_valid),
    .do_wr   (do_wr),
    .do_rd   (do_rd),
    .wbeats  (wbeats),
    .rbeats  (rbeats),
    .bus_ack (bus_ack),
    .busy    (seq_busy),
    .in_wr   (in_wr),
    .req     (seq_req),
    .idx     (idx),
    .rd_stb  (rd_stb),
    .finish  (finish)
  );

  pio_dbank #(.N_WORDS(N_WORDS), .DW(DW)) u_bank (
    .clk      (clk),
    .rst_n    (rst_ns),
    .sw_we    (reg_we && hit_data && !busy),
    .sw_idx   (doff[IW-1:0]),
    .sw_wdata (reg_wdata),
    .hw_we    (rd_stb),
    .hw_idx   (idx),
    .hw_wdata (bus_rdata),
    .words    (words)
  );

  // next-state for control and status
  always_comb begin
    opcode_n  = opcode_q;
    ie_n      = ie_q;
    len_n     = len_q;
    taddr_n   = taddr_q;
    go_n      = 1'b0;
    done_n    = done_q;
    operr_n   = operr_q;
    lockerr_n = lockerr_q;

    if (reg_we && hit_stat) begin
      if (reg_wdata[ST_DONE])    done_n    = 1'b0;
      if (reg_wdata[ST_OPERR])   operr_n   = 1'b0;
      if (reg_wdata[ST_LOCKERR]) lockerr_n = 1'b0;
    end

    if (reg_we && (hit_ctrl || hit_len || hit_taddr || hit_data)) begin
      if (busy) begin
        lockerr_n = 1'b1;
      end else if (hit_ctrl) begin
        opcode_n = reg_wdata[7:0];
        ie_n     = reg_wdata[CTRL_IE];
        go_n     = reg_wdata[CTRL_GO];
        if (reg_wdata[CTRL_GO]) begin
          done_n  = 1'b0;
          operr_n = 1'b0;
        end
      end else if (hit_len) begin
        len_n = reg_wdata[15:0];
      end else if (hit_taddr) begin
        taddr_n = reg_wdata[TW-1:0];
      end
    end

    if (finish) begin
      done_n = 1'b1;
      if (!op_valid) operr_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      opcode_q  <= '0;
      ie_q      <= 1'b0;
      go_q      <= 1'b0;
      len_q     <= '0;
      taddr_q   <= '0;
      done_q    <= 1'b0;
      operr_q   <= 1'b0;
      lockerr_q <= 1'b0;
    end else begin
      opcode_q  <= opcode_n;
      ie_q      <= ie_n;
      go_q      <= go_n;
      len_q     <= len_n;
      taddr_q   <= taddr_n;
      done_q    <= done_n;
      operr_q   <= operr_n;
      lockerr_q <= lockerr_n;
    end
  end

  // bus side
  assign bus_req    = seq_req;
  assign bus_write  = in_wr;
  assign bus_bridge = op_bridge;
  assign bus_addr   = op_bridge ? {{(TW-8){1'b0}}, taddr_q[7:0]} : taddr_q;
  assign bus_wdata  = words[idx];
  assign irq        = done_q && ie_q;

  // register read
  always_comb begin
    reg_rdata = '0;
    if (reg_raddr == AW'(REG_CTRL))
      reg_rdata = DW'({ie_q, go_q, opcode_q});
    else if (reg_raddr == AW'(REG_LEN))
      reg_rdata = DW'(len_q);
    else if (reg_raddr == AW'(REG_TADDR))
      reg_rdata = DW'(taddr_q);
    else if (reg_raddr == AW'(REG_STAT))
      reg_rdata = DW'({lockerr_q, operr_q, busy, done_q});
    else if (reg_raddr >= AW'(REG_DBASE) &&
             (reg_raddr - AW'(REG_DBASE)) < AW'(N_WORDS))
      reg_rdata = words[IW'(reg_raddr - AW'(REG_DBASE))];
  end

  // R1: requests happen only inside an operation
  p_req_in_busy_r1: assert property (@(posedge clk) disable iff (!rst_ns)
    bus_req |-> busy);
  // R11: beat contents hold until acknowledged
  p_beat_stable_r11: assert property (@(posedge clk) disable iff (!rst_ns)
    bus_req && !bus_ack |=> $stable(bus_addr) && $stable(bus_wdata) && $stable(bus_write));
  // R3: bridge targets stay inside the 8-bit space
  p_bridge_space_r3: assert property (@(posedge clk) disable iff (!rst_ns)
    bus_req && bus_bridge |-> bus_addr[TW-1:8] == '0);
  // R9: target address cannot move during an operation
  p_taddr_locked_r9: assert property (@(posedge clk) disable iff (!rst_ns)
    busy |=> $stable(taddr_q));
  // R7: done appears together with the end of busy
  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_ns)
    $rose(done_q) |-> !busy);
  // R10: an undecodable opcode never reaches the bus
  p_badop_quiet_r10: assert property (@(posedge clk) disable iff (!rst_ns)
    bus_req |-> op_valid);
endmodule

// File: tb/tb_pio_seq_top.sv
`timescale 1ns/1ps
module tb_pio_seq_top;
  logic        clk, rst_n, reg_we;
  logic [3:0]  reg_addr, reg_raddr;
  logic [31:0] reg_wdata, reg_rdata, bus_wdata, bus_rdata;
  logic        bus_req, bus_write, bus_bridge, bus_ack, irq;
  logic [15:0] bus_addr;

  int total = 0, bad = 0;
  int lat = 0;
  int nlog = 0;
  int unstable = 0;
  int cnt = 0;
  logic [15:0] h_addr;
  logic [31:0] h_wdata;
  logic        h_wr;
  logic [15:0] la [64];
  logic [31:0] ld [64];
  logic        lw [64];
  logic        lb [64];
  bit          finished = 0;

  pio_seq_top dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
    .bus_req(bus_req), .bus_write(bus_write), .bus_bridge(bus_bridge),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // wire-engine model: acknowledges after lat cycles, one-cycle ack, logs beats
  always @(negedge clk) begin
    if (!rst_n) begin
      bus_ack <= 1'b0;
      cnt = 0;
    end else if (bus_ack) begin
      bus_ack <= 1'b0;
      cnt = 0;
    end else if (bus_req) begin
      if (cnt != 0 && (bus_addr != h_addr || bus_wdata != h_wdata || bus_write != h_wr))
        unstable++;
      if (cnt == 0) begin
        h_addr = bus_addr; h_wdata = bus_wdata; h_wr = bus_write;
      end
      if (cnt >= lat) begin
        la[nlog % 64] = bus_addr;
        ld[nlog % 64] = bus_wdata;
        lw[nlog % 64] = bus_write;
        lb[nlog % 64] = bus_bridge;
        bus_rdata <= 32'hC0DE_0000 + 32'(nlog);
        bus_ack   <= 1'b1;
        nlog++;
      end else begin
        cnt++;
      end
    end
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 4'(a); reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    reg_raddr = 4'(a);
    #0.5 d = reg_rdata;
  endtask

  task automatic wait_done();
    logic [31:0] s;
    for (int i = 0; i < 500; i++) begin
      rd(3, s);
      if (s[0]) return;
    end
    chk(0, 1, "R7 done timeout");
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(3, v); chk(v, 0, "R7 status after reset");
    rd(0, v); chk(v, 0, "R1 control after reset");
    chk({31'd0, irq}, 0, "R8 irq after reset");
    chk({31'd0, bus_req}, 0, "R1 no request after reset");
  endtask

  task automatic t_dev_write();
    logic [31:0] v;
    int base;
    lat = 3; base = nlog;
    wr(4, 32'hA1A2_A3A4); wr(5, 32'hB1B2_B3B4);
    wr(2, 32'h1234); wr(1, 6);
    wr(0, 32'h118);
    rd(0, v); chk(v, 32'h018, "R1 go self-clears");
    rd(3, v); chk(v, 32'h2, "R1 busy after go");
    wr(2, 32'h5555); wr(4, 32'hDEAD);
    rd(3, v); chk((v >> 3) & 1, 1, "R9 locked write flagged");
    wait_done();
    chk(nlog - base, 2, "R4 six bytes give two beats");
    chk({31'd0, lw[base % 64]}, 1, "R2 device write direction");
    chk({31'd0, lb[base % 64]}, 0, "R2 device not bridge");
    chk({16'd0, la[base % 64]}, 32'h1234, "R3 device full address");
    chk(ld[base % 64], 32'hA1A2_A3A4, "R4 beat 0 word 0");
    chk(ld[(base + 1) % 64], 32'hB1B2_B3B4, "R4 beat 1 word 1");
    rd(2, v); chk(v, 32'h1234, "R9 address unchanged");
    rd(4, v); chk(v, 32'hA1A2_A3A4, "R9 data unchanged");
    rd(3, v); chk(v, 32'h9, "R7 done and sticky lock error");
    chk({31'd0, irq}, 0, "R8 irq off without enable");
    wr(3, 32'h9);
    rd(3, v); chk(v, 0, "R7 R9 write-one clears");
  endtask

  task automatic t_bridge_read();
    logic [31:0] v;
    int base;
    lat = 0; base = nlog;
    wr(2, 32'h03AB); wr(1, 4);
    wr(0, 32'h312);
    wait_done();
    chk(nlog - base, 1, "R4 four bytes one beat");
    chk({16'd0, la[base % 64]}, 32'h00AB, "R3 bridge address truncated");
    chk({30'd0, lb[base % 64], lw[base % 64]}, 32'h2, "R2 bridge read kind");
    rd(4, v); chk(v, 32'hC0DE_0000 + 32'(base), "R5 read word stored");
    chk({31'd0, irq}, 1, "R8 irq with enable");
    wr(3, 1);
    chk({31'd0, irq}, 0, "R8 irq clears with done");
  endtask

  task automatic t_read_cap();
    logic [31:0] v;
    int base;
    lat = 1; base = nlog;
    wr(2, 32'h0BEE); wr(1, 200);
    wr(0, 32'h114);
    wait_done();
    chk(nlog - base, 4, "R4 count capped at word count");
    chk({16'd0, la[(base + 3) % 64]}, 32'h0BEE, "R3 device address kept");
    rd(7, v); chk(v, 32'hC0DE_0000 + 32'(base + 3), "R5 last word stored");
    rd(5, v); chk(v, 32'hC0DE_0000 + 32'(base + 1), "R5 word order");
    wr(3, 1);
    base = nlog;
    wr(1, 0); wr(0, 32'h114);
    wait_done();
    chk(nlog - base, 0, "R4 zero count no beats");
    wr(3, 1);
  endtask

  task automatic t_wrrd();
    logic [31:0] v;
    int base;
    lat = 2; base = nlog;
    wr(4, 32'h1111_1111); wr(1, 32'h0408);
    wr(0, 32'h11C);
    wait_done();
    chk(nlog - base, 3, "R6 one write then two reads");
    chk({31'd0, lw[base % 64]}, 1, "R6 write phase first");
    chk(ld[base % 64], 32'h1111_1111, "R6 write word from data");
    chk({30'd0, lw[(base + 1) % 64], lw[(base + 2) % 64]}, 0, "R6 read phase after");
    rd(4, v); chk(v, 32'hC0DE_0000 + 32'(base + 1), "R6 read into word 0");
    rd(5, v); chk(v, 32'hC0DE_0000 + 32'(base + 2), "R6 read into word 1");
    wr(3, 1);
  endtask

  task automatic t_badop();
    logic [31:0] v;
    int base;
    base = nlog;
    wr(1, 8); wr(0, 32'h155);
    rd(3, v); chk(v, 32'h2, "R10 busy, not done one cycle after start");
    rd(3, v); chk(v, 32'h5, "R10 done and opcode error two cycles after");
    chk(nlog - base, 0, "R10 no bus request");
    wr(3, 32'h4);
    rd(3, v); chk(v, 32'h1, "R10 opcode error cleared alone");
    wr(3, 1);
  endtask

  initial begin
    reg_we = 1'b0; reg_addr = '0; reg_wdata = '0; reg_raddr = '0;
    bus_rdata = '0; bus_ack = 1'b0;
    rst_n = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_dev_write();
    t_bridge_read();
    t_read_cap();
    t_wrrd();
    t_badop();
    chk(32'(unstable), 0, "R11 beat held until ack");
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule